// File: doc/BRIEF.md
# Rate Selectable Periodic Divider

This block divides a 32.768 kHz clock-enable through a 15-stage binary count chain. A 4-bit rate code picks one of thirteen stages of that chain. The picked stage is the source for two outputs: a square wave that can be gated off, and a one-cycle periodic pulse that a downstream interrupt-flag register captures. The most significant stage of the chain produces the once-per-second pulse that starts the calendar advance.

A 3-bit oscillator field sets the chain's mode. One pattern lets the chain count. A second family of patterns keeps the chain parked at its midpoint. Every other pattern freezes the chain where it stands. When the chain is parked at its midpoint, the first one-second pulse after release comes half a second later.

Top module: `periodic_rate_divider`

## Requirements
- R1: With the square-wave enable high, `sqw_out` is a 50 % duty square wave at the frequency the rate code selects. Codes 1 and 2 give 256 Hz and 128 Hz. Codes 3 through 7 give 8192, 4096, 2048, 1024 and 512 Hz. Codes 8 through 15 give 256, 128, 64, 32, 16, 8, 4 and 2 Hz. Frequencies are measured in units of `tick_en` pulses (32768 per second). Outputs are registered and appear one clock after the enable that causes them.
- R2: `periodic_pulse` is high for exactly one clock on each rising edge of the selected stage. Its period in enables is 32768 divided by the selected frequency.
- R3: Rate code 0 holds `sqw_out` low and produces no `periodic_pulse`.
- R4: A low `sqw_en` holds `sqw_out` low, and the periodic pulses continue at the selected rate.
- R5: `osc_ctl` = 3'b010 lets the chain count. `osc_ctl` = 3'b110 or 3'b111 holds the chain at its midpoint value, and produces neither periodic pulses nor second ticks.
- R6: Every other `osc_ctl` pattern freezes the chain, which keeps its count, and produces no pulses.
- R7: After a release from the hold patterns to 3'b010 with the enable high every clock, the first `second_tick` appears 16384 clocks after the release. Each later tick follows 32768 clocks after the one before.
- R8: A change of rate code produces no spurious pulse. The first pulse after the change arrives on the next rising edge of the newly selected stage, within one new period.
- R9: While `tick_en` is low, nothing advances: there are no pulses and `sqw_out` is stable.
- R10: An asserted `rst_n` (active low, asynchronous) drives all outputs low and parks the chain at its midpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 32.768 kHz count enable, one clock wide |
| osc_ctl | input | 3 | Oscillator / chain mode field |
| rate_sel | input | 4 | Rate code selecting the divider stage |
| sqw_en | input | 1 | Square-wave output gate |
| sqw_out | output | 1 | Gated square wave |
| periodic_pulse | output | 1 | One-clock pulse per period of the selected stage |
| second_tick | output | 1 | One-clock pulse once per 32768 enables |

## Verification
The hardest condition to reach is the half-second alignment of the first tick after a hold, because it only shows after tens of thousands of enables. The bench therefore drives the enable high every clock and parks the chain with a hold pattern. It then times the first and second ticks from the exact release cycle. Glitch freedom on a rate change is reached by switching codes immediately after a pulse of the old rate. The bench then checks that the first new pulse lands within one new period, and that the next pulse follows exactly one period later.

// File: rtl/prd_pkg.sv
`timescale 1ns/1ps
package prd_pkg;

    typedef enum logic [1:0] {
        OSC_STOP = 2'd0,
        OSC_HOLD = 2'd1,
        OSC_RUN  = 2'd2
    } osc_mode_e;

    localparam int RATE_W = 4;

    // Stage index of the count chain for a non-zero rate code.
    function automatic logic [4:0] tap_index(input logic [RATE_W-1:0] code);
        if (code < 4'd3) begin
            return 5'(code) + 5'd5;
        end
        return 5'(code) - 5'd2;
    endfunction

endpackage

// File: rtl/prd_osc_ctrl.sv
`timescale 1ns/1ps
module prd_osc_ctrl
    import prd_pkg::*;
(
    input  logic [2:0] osc_ctl,
    output osc_mode_e  mode
);
    always_comb begin
        if (osc_ctl == 3'b010) begin
            mode = OSC_RUN;
        end else if (osc_ctl[2:1] == 2'b11) begin
            mode = OSC_HOLD;
        end else begin
            mode = OSC_STOP;
        end
    end
endmodule

// File: rtl/prd_tap_sel.sv
`timescale 1ns/1ps
module prd_tap_sel
    import prd_pkg::*;
#(
    parameter int CHAIN_W = 15
) (
    input  logic [RATE_W-1:0]  rate_sel,
    input  logic [CHAIN_W-1:0] cnt_now,
    input  logic [CHAIN_W-1:0] cnt_next,
    output logic               tap_valid,
    output logic               tap_now,
    output logic               tap_next
);
    localparam int IDX_W = $clog2(CHAIN_W);

    logic [IDX_W-1:0] idx;

    always_comb begin
        tap_valid = (rate_sel != '0);
        idx       = IDX_W'(tap_index(rate_sel));
        tap_now   = tap_valid & cnt_now[idx];
        tap_next  = tap_valid & cnt_next[idx];
    end
endmodule

// File: rtl/periodic_rate_divider.sv
`timescale 1ns/1ps
module periodic_rate_divider
    import prd_pkg::*;
#(
    parameter int CHAIN_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [2:0] osc_ctl,
    input  logic [3:0] rate_sel,
    input  logic       sqw_en,
    output logic       sqw_out,
    output logic       periodic_pulse,
    output logic       second_tick
);
    localparam logic [CHAIN_W-1:0] MID_CNT  = {1'b1, {(CHAIN_W-1){1'b0}}};
    localparam logic [CHAIN_W-1:0] LAST_CNT = '1;

    typedef struct packed {
        logic [CHAIN_W-1:0] cnt;
        logic               sqw;
        logic               pev;
        logic               sec;
    } state_t;

    state_t             st_q, st_d;
    osc_mode_e          mode;
    logic               adv;
    logic [CHAIN_W-1:0] cnt_nx;
    logic               tap_valid, tap_now, tap_next;

    prd_osc_ctrl u_osc (
        .osc_ctl (osc_ctl),
        .mode    (mode)
    );

    always_comb begin
        adv = (mode == OSC_RUN) && tick_en;
        unique case (mode)
            OSC_HOLD: cnt_nx = MID_CNT;
            OSC_RUN:  cnt_nx = adv ? st_q.cnt + 1'b1 : st_q.cnt;
            default:  cnt_nx = st_q.cnt;
        endcase
    end

    prd_tap_sel #(.CHAIN_W(CHAIN_W)) u_tap (
        .rate_sel  (rate_sel),
        .cnt_now   (st_q.cnt),
        .cnt_next  (cnt_nx),
        .tap_valid (tap_valid),
        .tap_now   (tap_now),
        .tap_next  (tap_next)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nx;
        st_d.sqw = sqw_en & tap_next;
        st_d.pev = tap_valid & adv & ~tap_now & tap_next;
        st_d.sec = adv & (st_q.cnt == LAST_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: MID_CNT, sqw: 1'b0, pev: 1'b0, sec: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sqw_out        = st_q.sqw;
    assign periodic_pulse = st_q.pev;
    assign second_tick    = st_q.sec;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_pulse |=> !periodic_pulse); // R2
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 4'd0) |=> (!sqw_out && !periodic_pulse)); // R3
    AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |=> !sqw_out); // R4
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OSC_HOLD) |=> (!periodic_pulse && !second_tick && st_q.cnt == MID_CNT)); // R5
    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OSC_STOP) |=> ($stable(st_q.cnt) && !periodic_pulse && !second_tick)); // R6
    AST_ENABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> (!periodic_pulse && !second_tick)); // R9
endmodule

// File: tb/periodic_rate_divider_tb.sv
`timescale 1ns/1ps
module periodic_rate_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n, tick_en, sqw_en;
    logic [2:0] osc_ctl;
    logic [3:0] rate_sel;
    logic       sqw_out, periodic_pulse, second_tick;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    periodic_rate_divider u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_en        (tick_en),
        .osc_ctl        (osc_ctl),
        .rate_sel       (rate_sel),
        .sqw_en         (sqw_en),
        .sqw_out        (sqw_out),
        .periodic_pulse (periodic_pulse),
        .second_tick    (second_tick)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int freq_hz(input int code);
        case (code)
            1: return 256;   2: return 128;   3: return 8192;  4: return 4096;
            5: return 2048;  6: return 1024;  7: return 512;   8: return 256;
            9: return 128;   10: return 64;   11: return 32;   12: return 16;
            13: return 8;    14: return 4;    15: return 2;
            default: return 0;
        endcase
    endfunction

    // Clocks from now until periodic_pulse is seen at a negedge (limit bounded).
    task automatic wait_pev(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!periodic_pulse && n < limit);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, hi, bad, per, base;
        bit stable_ok;
        rst_n = 1'b0; tick_en = 1'b1; osc_ctl = 3'b110; rate_sel = 4'd0; sqw_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(!sqw_out && !periodic_pulse && !second_tick, "R10 reset outputs", {sqw_out, periodic_pulse, second_tick}, 0);
        rst_n = 1'b1;

        // R5: hold pattern 111, nothing happens
        osc_ctl = 3'b111;
        bad = 0;
        repeat (50) begin @(negedge clk); bad += int'(periodic_pulse) + int'(second_tick); end
        chk(bad == 0, "R5 hold quiet", bad, 0);

        // R7 and R3: release with code 0, time the ticks
        osc_ctl = 3'b010;
        n = 0; bad = 0;
        do begin
            @(negedge clk); n++;
            bad += int'(sqw_out) + int'(periodic_pulse);
        end while (!second_tick && n < 40000);
        chk(n == 16384, "R7 first tick", n, 16384);
        n = 0;
        do begin
            @(negedge clk); n++;
            bad += int'(sqw_out) + int'(periodic_pulse);
        end while (!second_tick && n < 40000);
        chk(n == 32768, "R7 second tick", n, 32768);
        chk(bad == 0, "R3 code zero idle", bad, 0);

        // R1 and R2: sweep every non-zero rate code
        sqw_en = 1'b1;
        for (int c = 1; c < 16; c++) begin
            rate_sel = 4'(c);
            per = 32768 / freq_hz(c);
            wait_pev(40000, n);
            n = 0; hi = 0;
            do begin
                hi += int'(sqw_out);
                n++;
                @(negedge clk);
            end while (!periodic_pulse && n < 40000);
            chk(n == per, $sformatf("R2 period code %0d", c), n, per);
            chk(hi == per / 2, $sformatf("R1 sqw high code %0d", c), hi, per / 2);
        end

        // R8: switch right after a 2 Hz pulse to code 4 (period 8)
        rate_sel = 4'd4;
        wait_pev(100, n);
        chk(n >= 1 && n <= 8, "R8 first pulse after change", n, 8);
        wait_pev(100, n);
        chk(n == 8, "R8 following period", n, 8);

        // R4: gate off square wave, pulses continue with code 3 (period 4)
        rate_sel = 4'd3; sqw_en = 1'b0;
        @(negedge clk);
        hi = 0; bad = 0;
        repeat (40) begin @(negedge clk); hi += int'(sqw_out); bad += int'(periodic_pulse); end
        chk(hi == 0, "R4 sqw held low", hi, 0);
        chk(bad == 10, "R4 pulses continue", bad, 10);

        // R9: enable low freezes everything
        sqw_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        @(negedge clk);
        base = int'(sqw_out); stable_ok = 1'b1; bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (int'(sqw_out) != base) stable_ok = 1'b0;
            bad += int'(periodic_pulse) + int'(second_tick);
        end
        chk(stable_ok, "R9 sqw stable", int'(sqw_out), base);
        chk(bad == 0, "R9 no pulses", bad, 0);
        tick_en = 1'b1;

        // R6: stop pattern freezes chain, resumes afterwards
        osc_ctl = 3'b000;
        @(negedge clk);
        base = int'(sqw_out); stable_ok = 1'b1; bad = 0;
        repeat (50) begin
            @(negedge clk);
            if (int'(sqw_out) != base) stable_ok = 1'b0;
            bad += int'(periodic_pulse) + int'(second_tick);
        end
        chk(bad == 0 && stable_ok, "R6 stop frozen", bad, 0);
        osc_ctl = 3'b010;
        wait_pev(100, n);
        wait_pev(100, n);
        chk(n == 4, "R6 resume period", n, 4);

        // R10: asynchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(!sqw_out && !periodic_pulse && !second_tick, "R10 async reset", {sqw_out, periodic_pulse, second_tick}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!periodic_pulse && !second_tick, "R10 released from midpoint", {periodic_pulse, second_tick}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule